// File: doc/BRIEF.md
# Slot-Aware Reset Sequencer

This block produces the reset outputs of a plug-in processor board that sits in a backplane. When power is good it releases a set of domain resets one at a time, with a programmable gap between them. The processor domain is always released last, and the local PCI reset follows it. If power is lost, every reset is asserted at once without waiting for a clock edge, and the sequence starts again from the beginning when power returns.

When power comes up, the sequencer captures three settings: which kind of slot the board is in, taken from the synchronized backplane system-enable input; a two-bit operating mode; and the gap length. These captured values decide how the board treats the backplane:

- In the system slot it generates the backplane reset.
- In a peripheral slot it can follow the backplane reset as a full local reset.
- Alternatively, in a peripheral slot it can keep its backplane bridge in reset and isolated.

The captured settings stay fixed until the next power-up.

Top module: `slot_reset_seq`

## Requirements
- R1: While `power_ok` is low or `rst_n` is low, every `dom_rst` bit, `pci_rst` and `bridge_rst` are 1, and `bp_rst_drive` and `bridge_iso` are 0.
- R2: No reset is released before power is good. The settings are captured on the third rising edge after `power_ok` goes high, with `rst_n` high. This is the capture edge.
- R3: The domain resets are released in index order, from `dom_rst[0]` up to `dom_rst[N_DOM-1]` (the processor domain), with at most one release per clock. Stage k is released on the edge that falls (k+1)·(`gap_cfg`+1) cycles after the capture edge.
- R4: `pci_rst` is released `gap_cfg`+1 cycles after the processor domain, and never while any domain reset is still asserted.
- R5: A low level on `power_ok` asserts all domain resets, `pci_rst` and `bridge_rst` combinationally, without a clock edge. It also clears the captured settings.
- R6: `bp_sysen_n`, `mode_cfg` and `gap_cfg` are sampled only at the capture edge. Later changes have no effect until the next power-up.
- R7: The mode encoding is: 2'b00 normal (the default for a tied-off input), 2'b01 follow, 2'b10 standalone. The value 2'b11 behaves exactly like normal.
- R8: System slot (`bp_sysen_n` low at capture) in normal or follow mode: from the capture edge, `bp_rst_drive` equals `pci_rst`, and `bp_rst_n` is ignored.
- R9: System slot in standalone mode: `bp_rst_drive` is 1 continuously from the capture edge, including after the local sequence completes.
- R10: Peripheral slot in follow mode: on the third edge after `bp_rst_n` goes low, all resets are reasserted. On the third edge after it returns high, the sequence restarts from stage 0 with the captured gap.
- R11: Peripheral slot in normal or standalone mode: `bridge_iso` and `bridge_rst` are 1 from the capture edge, `bp_rst_drive` is 0, and `bp_rst_n` has no effect on any reset.
- R12: Peripheral slot in follow mode: `bridge_iso` and `bp_rst_drive` stay 0, and `bridge_rst` equals `pci_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| power_ok | input | 1 | Power-good level, asynchronous |
| bp_sysen_n | input | 1 | Backplane system-enable, low in the system slot |
| bp_rst_n | input | 1 | Backplane reset in, active low |
| mode_cfg | input | 2 | Slot behaviour mode (R7) |
| gap_cfg | input | GAP_W | Inter-stage gap minus one, in cycles |
| dom_rst | output | N_DOM | Domain resets, active high; top bit is the processor |
| pci_rst | output | 1 | Local PCI reset, active high |
| bp_rst_drive | output | 1 | Drive enable for the backplane reset |
| bridge_iso | output | 1 | Backplane bridge isolation |
| bridge_rst | output | 1 | Backplane bridge reset, active high |

## Verification
A reference model in the bench, written with integers and sample queues, predicts every output on every clock. The main sequence is run with gaps of 0, 1, 2 and 3. Each gap length separates an off-by-one in the stage timer from a wrong stage order.

Each slot and mode pair is tried, together with backplane reset pulses both during sequencing and after it. This tells a follow-mode local reset apart from the pulse being ignored or the bridge being isolated. Configuration changes after the capture edge, and power drops observed one time unit after the drop, check that the captured settings hold and that reset assertion is asynchronous.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    // Slot behaviour selected at power-up; 2'b00 is the default.
    typedef enum logic [1:0] {
        MODE_NORMAL     = 2'b00,
        MODE_FOLLOW     = 2'b01,
        MODE_STANDALONE = 2'b10,
        MODE_RESERVED   = 2'b11
    } slot_mode_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_OFF,    // power not good, all resets held
        ST_STAGE,  // counting a gap, releasing one stage per gap
        ST_RUN,    // every stage released
        ST_HOLD    // backplane reset followed as a local reset
    } seq_state_e;

    // Reserved code falls back to normal behaviour.
    function automatic slot_mode_e decode_mode(input logic [1:0] raw);
        slot_mode_e m;
        unique case (raw)
            2'b01:   m = MODE_FOLLOW;
            2'b10:   m = MODE_STANDALONE;
            default: m = MODE_NORMAL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rseq_gap_timer.sv
module rseq_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap_in,
    input  logic             run,
    output logic             tick
);
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] cnt_q;

    // Gap length captured once per power-up.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            gap_q <= '0;
        end else if (load) begin
            gap_q <= gap_in;
        end
    end

    // Counts 0..gap_q while running; held at zero otherwise.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (run && !tick) begin
            cnt_q <= cnt_q + GAP_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign tick = run && (cnt_q == gap_q);
endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int N_DOM = 4
) (
    input  logic           clk,
    input  logic           arst_n,
    input  logic           pwr_good,
    input  logic           hold_req,
    input  logic           gap_tick,
    output logic           capture,
    output logic           timer_run,
    output logic [N_DOM:0] rel_vec
);
    localparam int N_STEP = N_DOM + 1;
    localparam int IDX_W  = (N_STEP > 1) ? $clog2(N_STEP) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DOM);

    seq_state_e     state_q, state_d;
    logic [IDX_W-1:0] stg_q;
    logic [N_DOM:0] rel_q;
    logic [N_DOM:0] step_hit;
    logic           release_now;
    logic           last_step;

    for (genvar i = 0; i <= N_DOM; i++) begin : g_hit
        assign step_hit[i] = (stg_q == IDX_W'(i));
    end

    assign last_step   = (stg_q == LAST_IDX);
    assign release_now = (state_q == ST_STAGE) && gap_tick && !hold_req;

    // Transitions: power_up OFF->STAGE, advance STAGE->STAGE, done STAGE->RUN,
    // bp_enter STAGE/RUN->HOLD, bp_exit HOLD->STAGE; power_loss is asynchronous.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (pwr_good) state_d = ST_STAGE;
            ST_STAGE: begin
                if (hold_req)                   state_d = ST_HOLD;
                else if (gap_tick && last_step) state_d = ST_RUN;
            end
            ST_RUN:   if (hold_req)  state_d = ST_HOLD;
            ST_HOLD:  if (!hold_req) state_d = ST_STAGE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // Stage index and release vector.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg_q <= '0;
            rel_q <= '0;
        end else if (state_d == ST_HOLD) begin
            stg_q <= '0;
            rel_q <= '0;
        end else if (release_now) begin
            rel_q <= rel_q | step_hit;
            if (!last_step) stg_q <= stg_q + IDX_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        capture   = (state_q == ST_OFF) && pwr_good;
        timer_run = (state_q == ST_STAGE);
        rel_vec   = rel_q;
    end
endmodule

// File: rtl/rseq_slot_policy.sv
module rseq_slot_policy
    import rseq_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       capture,
    input  logic       sysen_n_s,
    input  logic [1:0] mode_raw,
    input  logic       bp_rst_n_s,
    input  logic       pci_rst_i,
    output logic       hold_req,
    output logic       bp_rst_drive,
    output logic       bridge_iso,
    output logic       bridge_rst
);
    logic       valid_q;
    logic       sys_slot_q;
    slot_mode_e mode_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            valid_q    <= 1'b0;
            sys_slot_q <= 1'b0;
            mode_q     <= MODE_NORMAL;
        end else if (capture) begin
            valid_q    <= 1'b1;
            sys_slot_q <= !sysen_n_s;
            mode_q     <= decode_mode(mode_raw);
        end
    end

    always_comb begin
        hold_req     = 1'b0;
        bp_rst_drive = 1'b0;
        bridge_iso   = 1'b0;
        if (valid_q) begin
            if (sys_slot_q) begin
                bp_rst_drive = (mode_q == MODE_STANDALONE) || pci_rst_i;
            end else if (mode_q == MODE_FOLLOW) begin
                hold_req = !bp_rst_n_s;
            end else begin
                bridge_iso = 1'b1;
            end
        end
        bridge_rst = pci_rst_i || bridge_iso;
    end
endmodule

// File: rtl/slot_reset_seq.sv
module slot_reset_seq
    import rseq_pkg::*;
#(
    parameter int N_DOM       = 4,
    parameter int GAP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_ok,
    input  logic             bp_sysen_n,
    input  logic             bp_rst_n,
    input  logic [1:0]       mode_cfg,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic [N_DOM-1:0] dom_rst,
    output logic             pci_rst,
    output logic             bp_rst_drive,
    output logic             bridge_iso,
    output logic             bridge_rst
);
    logic           arst_n;
    logic           pwr_good;
    logic           sysen_n_s;
    logic           bp_rst_n_s;
    logic           capture;
    logic           timer_run;
    logic           gap_tick;
    logic           hold_req;
    logic [N_DOM:0] rel_vec;

    // Power loss acts as an asynchronous reset of the whole sequencer.
    assign arst_n = rst_n & power_ok;

    rseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pg_sync (
        .clk(clk), .arst_n(arst_n), .d(1'b1), .q(pwr_good)
    );

    rseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_bp_sync (
        .clk(clk), .arst_n(arst_n),
        .d({bp_sysen_n, bp_rst_n}), .q({sysen_n_s, bp_rst_n_s})
    );

    rseq_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk(clk), .arst_n(arst_n), .load(capture), .gap_in(gap_cfg),
        .run(timer_run), .tick(gap_tick)
    );

    rseq_fsm #(.N_DOM(N_DOM)) u_fsm (
        .clk(clk), .arst_n(arst_n), .pwr_good(pwr_good), .hold_req(hold_req),
        .gap_tick(gap_tick), .capture(capture), .timer_run(timer_run),
        .rel_vec(rel_vec)
    );

    assign dom_rst = ~rel_vec[N_DOM-1:0];
    assign pci_rst = ~rel_vec[N_DOM];

    rseq_slot_policy u_policy (
        .clk(clk), .arst_n(arst_n), .capture(capture), .sysen_n_s(sysen_n_s),
        .mode_raw(mode_cfg), .bp_rst_n_s(bp_rst_n_s), .pci_rst_i(pci_rst),
        .hold_req(hold_req), .bp_rst_drive(bp_rst_drive),
        .bridge_iso(bridge_iso), .bridge_rst(bridge_rst)
    );
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker #(
    parameter int N_DOM = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             power_ok,
    input logic [N_DOM-1:0] dom_rst,
    input logic             pci_rst,
    input logic             bp_rst_drive,
    input logic             bridge_iso,
    input logic             bridge_rst
);
    logic [N_DOM:0] all_rst;
    assign all_rst = {pci_rst, dom_rst};

    for (genvar i = 0; i < N_DOM - 1; i++) begin : g_order
        assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !dom_rst[i+1] |-> !dom_rst[i]);
    end

    assert_one_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(all_rst) & ~all_rst) <= 1);

    assert_pci_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_rst |-> (dom_rst == '0));

    assert_power_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |-> ((&dom_rst) && pci_rst && bridge_rst));

    assert_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst[0]) |-> power_ok);

    assert_isolate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_iso |-> (bridge_rst && !bp_rst_drive));
endmodule

bind slot_reset_seq rseq_checker #(.N_DOM(N_DOM)) u_chk (
    .clk(clk), .rst_n(rst_n), .power_ok(power_ok), .dom_rst(dom_rst),
    .pci_rst(pci_rst), .bp_rst_drive(bp_rst_drive), .bridge_iso(bridge_iso),
    .bridge_rst(bridge_rst)
);

// File: tb/tb_slot_reset_seq.sv
module tb_slot_reset_seq;
    localparam int N_DOM = 4;
    localparam int GAP_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic             rst_n, power_ok, bp_sysen_n, bp_rst_n;
    logic [1:0]       mode_cfg;
    logic [GAP_W-1:0] gap_cfg;
    logic [N_DOM-1:0] dom_rst;
    logic             pci_rst, bp_rst_drive, bridge_iso, bridge_rst;

    slot_reset_seq #(.N_DOM(N_DOM), .GAP_W(GAP_W)) dut (
        .clk(clk), .rst_n(rst_n), .power_ok(power_ok), .bp_sysen_n(bp_sysen_n),
        .bp_rst_n(bp_rst_n), .mode_cfg(mode_cfg), .gap_cfg(gap_cfg),
        .dom_rst(dom_rst), .pci_rst(pci_rst), .bp_rst_drive(bp_rst_drive),
        .bridge_iso(bridge_iso), .bridge_rst(bridge_rst)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   n_edge = 0, m_age = 0, m_start = 0, m_gap = 0, m_ph = 0; // ph: 0 off, 1 active, 2 hold
    bit   m_valid = 0, m_slot = 0;
    int   m_mode = 0;
    logic sysq[$];
    logic bpq[$];

    function automatic int eff_mode();
        return (m_mode == 3) ? 0 : m_mode;
    endfunction

    function automatic int rel_count();
        int r;
        if (m_ph != 1) return 0;
        r = (n_edge - m_start) / (m_gap + 1);
        return (r > N_DOM + 1) ? N_DOM + 1 : r;
    endfunction

    always @(posedge clk) begin
        logic old_sys, old_bp;
        int   r;
        logic [N_DOM-1:0] e_dom;
        logic e_pci, e_drv, e_iso;
        n_edge++;
        if (!rst_n || !power_ok) begin
            m_ph = 0; m_valid = 0; m_slot = 0; m_age = 0;
            sysq.delete(); bpq.delete();
        end else begin
            old_sys = (sysq.size() >= 2) ? sysq[1] : 1'b0;
            old_bp  = (bpq.size()  >= 2) ? bpq[1]  : 1'b0;
            if (m_ph == 0) begin
                if (m_age >= 2) begin
                    m_ph = 1; m_start = n_edge; m_valid = 1;
                    m_slot = !old_sys; m_mode = int'(mode_cfg); m_gap = int'(gap_cfg);
                end
            end else if (m_valid && !m_slot && eff_mode() == 1 && !old_bp) begin
                m_ph = 2;
            end else if (m_ph == 2) begin
                m_ph = 1; m_start = n_edge;
            end
            sysq.push_front(bp_sysen_n);
            bpq.push_front(bp_rst_n);
            if (sysq.size() > 2) void'(sysq.pop_back());
            if (bpq.size() > 2)  void'(bpq.pop_back());
            m_age++;
        end
        r = rel_count();
        for (int i = 0; i < N_DOM; i++) e_dom[i] = !(r > i);
        e_pci = !(r > N_DOM);
        e_drv = m_valid && m_slot && (eff_mode() == 2 || e_pci);
        e_iso = m_valid && !m_slot && eff_mode() != 1;
        #2;
        if (!done) begin
            chk("R3", "dom_rst per-cycle", int'(dom_rst), int'(e_dom));
            chk("R4", "pci_rst per-cycle", int'(pci_rst), int'(e_pci));
            chk((eff_mode() == 2) ? "R9" : "R8", "bp_rst_drive per-cycle",
                int'(bp_rst_drive), int'(e_drv));
            chk("R11", "bridge_iso per-cycle", int'(bridge_iso), int'(e_iso));
            chk("R12", "bridge_rst per-cycle", int'(bridge_rst), int'(e_pci || e_iso));
        end
    end

    // ---------------- helpers ----------------
    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #3;
    endtask

    task automatic power_up(input logic sysen_n, input logic [1:0] mode, input int gap);
        @(negedge clk);
        bp_sysen_n = sysen_n; mode_cfg = mode; gap_cfg = GAP_W'(gap); power_ok = 1'b1;
    endtask

    task automatic power_down();
        @(negedge clk);
        power_ok = 1'b0;
        #1;
        chk("R5", "dom_rst immediate", int'(dom_rst), 'hF);
        chk("R5", "pci_rst immediate", int'(pci_rst), 1);
        chk("R5", "bridge_rst immediate", int'(bridge_rst), 1);
        edges(3);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 0; power_ok = 0; bp_sysen_n = 1; bp_rst_n = 1; mode_cfg = 0; gap_cfg = 0;
        edges(3);
        chk("R1", "dom_rst in reset", int'(dom_rst), 'hF);
        chk("R1", "pci_rst in reset", int'(pci_rst), 1);
        chk("R1", "bp_rst_drive in reset", int'(bp_rst_drive), 0);
        chk("R1", "bridge_iso in reset", int'(bridge_iso), 0);
        @(negedge clk); rst_n = 1;
        edges(4);
        chk("R1", "dom_rst power low", int'(dom_rst), 'hF);
        chk("R1", "bridge_rst power low", int'(bridge_rst), 1);

        // System slot, normal, gap 2: capture at edge 3, stage k at 3+3(k+1).
        power_up(1'b0, 2'b00, 2);
        edges(5);
        chk("R2", "nothing released before first stage", int'(dom_rst), 'hF);
        edges(1);
        chk("R3", "stage 0 released first", int'(dom_rst), 'hE);
        chk("R8", "system slot drives backplane reset", int'(bp_rst_drive), 1);
        @(negedge clk); mode_cfg = 2'b10; gap_cfg = 0; bp_sysen_n = 1;
        edges(3);
        chk("R6", "gap unchanged after capture", int'(dom_rst), 'hC);
        edges(6);
        chk("R3", "processor domain released last", int'(dom_rst), 'h0);
        chk("R4", "pci still held after processor", int'(pci_rst), 1);
        edges(2);
        chk("R4", "pci held one cycle before its stage", int'(pci_rst), 1);
        edges(1);
        chk("R4", "pci released", int'(pci_rst), 0);
        chk("R8", "drive follows pci", int'(bp_rst_drive), 0);
        chk("R6", "slot unchanged after capture", int'(bridge_iso), 0);
        power_down();

        // System slot, standalone, gap 0.
        power_up(1'b0, 2'b10, 0);
        edges(3);
        chk("R9", "standalone drive from capture", int'(bp_rst_drive), 1);
        edges(5);
        chk("R9", "sequence done", int'(pci_rst), 0);
        chk("R9", "standalone drive held", int'(bp_rst_drive), 1);
        power_down();

        // Peripheral slot, follow, gap 1: stages at 5,7,9,11, pci at 13.
        power_up(1'b1, 2'b01, 1);
        edges(13);
        chk("R12", "pci released in follow", int'(pci_rst), 0);
        chk("R12", "no isolation in follow", int'(bridge_iso), 0);
        chk("R12", "bridge reset follows pci", int'(bridge_rst), 0);
        chk("R12", "no backplane drive", int'(bp_rst_drive), 0);
        @(negedge clk); bp_rst_n = 0;
        edges(2);
        chk("R10", "still released before sync", int'(pci_rst), 0);
        edges(1);
        chk("R10", "full local reset", int'(dom_rst), 'hF);
        chk("R10", "pci reasserted", int'(pci_rst), 1);
        edges(4);
        @(negedge clk); bp_rst_n = 1;
        edges(3);
        chk("R10", "held on exit edge", int'(dom_rst), 'hF);
        edges(2);
        chk("R10", "restart from stage 0", int'(dom_rst), 'hE);
        @(negedge clk); bp_rst_n = 0;
        edges(3);
        chk("R10", "reset during sequencing", int'(dom_rst), 'hF);
        @(negedge clk); bp_rst_n = 1;
        edges(20);
        chk("R10", "sequence completes again", int'(pci_rst), 0);
        power_down();

        // Peripheral slot, reserved code (normal), gap 3: pci at 3+5*4 = 23.
        power_up(1'b1, 2'b11, 3);
        edges(3);
        chk("R7", "reserved code isolates like normal", int'(bridge_iso), 1);
        chk("R11", "bridge held in reset", int'(bridge_rst), 1);
        @(negedge clk); bp_rst_n = 0;
        edges(8);
        @(negedge clk); bp_rst_n = 1;
        edges(12);
        chk("R11", "backplane reset ignored", int'(pci_rst), 0);
        chk("R11", "domains released", int'(dom_rst), 'h0);
        chk("R11", "bridge still in reset", int'(bridge_rst), 1);
        chk("R11", "no drive when isolated", int'(bp_rst_drive), 0);
        power_down();

        // System slot, follow code, gap 0, backplane reset asserted: pci at 8.
        @(negedge clk); bp_rst_n = 0;
        power_up(1'b0, 2'b01, 0);
        edges(7);
        chk("R8", "drive while pci held", int'(bp_rst_drive), 1);
        edges(1);
        chk("R8", "pci released despite bp reset", int'(pci_rst), 0);
        chk("R8", "drive drops with pci", int'(bp_rst_drive), 0);

        @(negedge clk); rst_n = 0;
        #1;
        chk("R1", "chip reset reasserts all", int'(dom_rst), 'hF);
        edges(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule